// File: doc/BRIEF.md
# Overcurrent Trip Supervisor

This block guards a three-phase half-bridge driver. It watches a digital overcurrent flag, a low-side undervoltage flag and a drive-enable input, all already synchronous to the block clock. From them it produces one shutdown signal that forces all six gate outputs off, and one request that pulls the active-low fault pad down.

An overcurrent is accepted only after the flag stays high for a set number of consecutive clock samples. Shorter pulses are treated as noise. Once accepted, the trip is latched. It stays latched for as long as the flag stays high. After the flag drops, a blocking timer counts a set number of consecutive low samples. This timer stands in for the recharge of an external RC timing node. The latch releases only when that count completes, and any high sample during the count starts it again from zero.

Undervoltage is not latched. It drives shutdown and the fault request directly and releases as soon as the flag drops. A low enable only forces shutdown and does not raise the fault request.

Top module: `oc_protect_supervisor`

## Requirements
- R1: The trip latch sets at the clock edge that takes the QUAL_CYCLES-th consecutive high sample of `oc_flag`. A run of fewer high samples has no effect on `shutdown` or `fault_pull`.
- R2: While the trip latch is set, `shutdown` and `fault_pull` are both 1 (1 means active), starting in the cycle right after the accepting edge.
- R3: The trip latch stays set for any number of cycles while `oc_flag` stays high.
- R4: After the last high sample, the latch clears at the edge that takes the CLEAR_CYCLES-th consecutive low sample of `oc_flag`. Both outputs drop from that cycle on, unless undervoltage or enable holds them.
- R5: Any high sample of `oc_flag` while the latch is set restarts the blocking count from zero, whether the pulse would qualify or not.
- R6: `uv_flag` high sets `shutdown` and `fault_pull` in the same cycle, without waiting for a clock edge. Both follow `uv_flag` low again at once, with nothing latched.
- R7: `drv_enable` low sets `shutdown` in the same cycle and leaves `fault_pull` unchanged.
- R8: A synchronous reset (`rst_n` low at a rising edge) clears the trip latch and all counts. This holds even if `oc_flag` is high during the reset.
- R9: `fault_pull` is the OR of the trip latch and the live `uv_flag`. When undervoltage ends while a trip is latched, the fault stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| oc_flag | input | 1 | Overcurrent comparator result, synchronous, 1 = overcurrent |
| uv_flag | input | 1 | Low-side undervoltage, synchronous, 1 = supply too low |
| drv_enable | input | 1 | Drive enable, 0 forces all gates off |
| shutdown | output | 1 | 1 = turn all six gate outputs off |
| fault_pull | output | 1 | 1 = pull the active-low fault pad low |

## Verification
The two outputs are combinational from the trip latch and the live inputs. A change in `uv_flag` or `drv_enable` therefore appears in the same cycle. An accepted trip appears right after the edge that takes the QUAL_CYCLES-th high sample, and a release right after the edge that takes the CLEAR_CYCLES-th low sample. The bench sets up inputs on the falling edge and records the expected result for that cycle in a queue. A monitor pops and compares each entry a quarter period after the next rising edge, so every comparison sees exactly one new latch update together with the inputs that caused it. Scenarios cover short glitches, long holds, exact release counts, restarts during the blocking count, and undervoltage overlapping a trip.

// File: rtl/oc_protect_pkg.sv
// Package: shared types for the overcurrent trip supervisor.
// Assumes nothing beyond being compiled before the modules that import it.
package oc_protect_pkg;

    // Trip latch states: no trip, trip input still present, blocking count running.
    typedef enum logic [1:0] {
        TRIP_IDLE  = 2'd0,
        TRIP_HOLD  = 2'd1,
        TRIP_BLANK = 2'd2
    } trip_state_e;

endpackage

// File: rtl/trip_qualifier.sv
// Module: trip_qualifier
// Counts consecutive high samples of the trip input. It reports the trip as
// accepted while the input is high and at least QUAL_CYCLES samples have been
// seen, the current one included.
// Assumes: trip_in is synchronous to clk, QUAL_CYCLES >= 1.
module trip_qualifier #(
    parameter int QUAL_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_in,
    output logic accepted
);

    localparam int QW = (QUAL_CYCLES > 1) ? $clog2(QUAL_CYCLES) : 1;
    localparam logic [QW-1:0] QMAX = QW'(QUAL_CYCLES - 1);

    logic [QW-1:0] run_cnt;

    // Count the high run, saturating at the acceptance point; clear on a low sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!trip_in) begin
            run_cnt <= '0;
        end else if (run_cnt != QMAX) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // Accept once the current sample completes the required run.
    always_comb begin
        accepted = trip_in && (run_cnt == QMAX);
    end

endmodule

// File: rtl/trip_latch_timer.sv
// Module: trip_latch_timer
// Holds an accepted overcurrent trip. The blocking count runs only while the
// trip input is low and restarts on every high sample. The latch releases at
// the edge that takes the CLEAR_CYCLES-th consecutive low sample.
// Assumes: accepted comes from trip_qualifier on the same trip_in, CLEAR_CYCLES >= 1.
module trip_latch_timer
    import oc_protect_pkg::*;
#(
    parameter int CLEAR_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accepted,
    input  logic trip_in,
    output logic tripped
);

    localparam int CW = (CLEAR_CYCLES > 1) ? $clog2(CLEAR_CYCLES) : 1;
    localparam logic [CW-1:0] CMAX = CW'(CLEAR_CYCLES - 1);

    trip_state_e   state_q, state_d;
    logic [CW-1:0] blank_q, blank_d;

    // Next-state logic for the latch and its blocking count.
    always_comb begin
        state_d = state_q;
        blank_d = blank_q;
        unique case (state_q)
            TRIP_IDLE: begin
                if (accepted) begin
                    state_d = TRIP_HOLD;
                    blank_d = '0;
                end
            end
            TRIP_HOLD, TRIP_BLANK: begin
                if (trip_in) begin
                    state_d = TRIP_HOLD;
                    blank_d = '0;
                end else if (blank_q == CMAX) begin
                    state_d = TRIP_IDLE;
                    blank_d = '0;
                end else begin
                    state_d = TRIP_BLANK;
                    blank_d = blank_q + 1'b1;
                end
            end
            default: begin
                state_d = TRIP_IDLE;
                blank_d = '0;
            end
        endcase
    end

    // State and count registers with synchronous reset to no-trip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TRIP_IDLE;
            blank_q <= '0;
        end else begin
            state_q <= state_d;
            blank_q <= blank_d;
        end
    end

    // Latch is set in either non-idle state.
    always_comb begin
        tripped = (state_q != TRIP_IDLE);
    end

endmodule

// File: rtl/fault_merge.sv
// Module: fault_merge
// Combines the latched trip, the live undervoltage flag and the enable into
// the global shutdown and the fault pad pull-down request.
// Assumes: all inputs are glitch-free levels in the clk domain.
module fault_merge (
    input  logic tripped,
    input  logic uv_flag,
    input  logic drv_enable,
    output logic shutdown,
    output logic fault_pull
);

    // Fault on trip or undervoltage; shutdown also when the drive is disabled.
    always_comb begin
        fault_pull = tripped | uv_flag;
        shutdown   = tripped | uv_flag | ~drv_enable;
    end

endmodule

// File: rtl/oc_protect_supervisor.sv
// Module: oc_protect_supervisor (top)
// Protection supervisor for a three-phase gate driver. It qualifies and
// latches overcurrent, passes undervoltage straight through, and drives the
// global shutdown and the active-low fault pull-down request.
// Assumes: oc_flag, uv_flag and drv_enable are already synchronous to clk.
module oc_protect_supervisor #(
    parameter int QUAL_CYCLES  = 8,
    parameter int CLEAR_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_flag,
    input  logic uv_flag,
    input  logic drv_enable,
    output logic shutdown,
    output logic fault_pull
);

    logic oc_accepted;
    logic tripped;

    trip_qualifier #(
        .QUAL_CYCLES(QUAL_CYCLES)
    ) qual_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .trip_in  (oc_flag),
        .accepted (oc_accepted)
    );

    trip_latch_timer #(
        .CLEAR_CYCLES(CLEAR_CYCLES)
    ) latch_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .accepted (oc_accepted),
        .trip_in  (oc_flag),
        .tripped  (tripped)
    );

    fault_merge merge_i (
        .tripped    (tripped),
        .uv_flag    (uv_flag),
        .drv_enable (drv_enable),
        .shutdown   (shutdown),
        .fault_pull (fault_pull)
    );

endmodule

// File: rtl/oc_protect_checker.sv
// Module: oc_protect_checker
// Property checks for oc_protect_supervisor, attached by bind. It keeps its
// own run counters of the trip input so that timing windows need no deep $past.
// Assumes: same parameters as the bound instance.
module oc_protect_checker #(
    parameter int QUAL_CYCLES  = 8,
    parameter int CLEAR_CYCLES = 64
) (
    input logic clk,
    input logic rst_n,
    input logic oc_flag,
    input logic uv_flag,
    input logic drv_enable,
    input logic tripped,
    input logic shutdown,
    input logic fault_pull
);

    int unsigned hi_run;
    int unsigned lo_run;

    // Track consecutive high and low samples of the trip input, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= 0;
            lo_run <= 0;
        end else if (oc_flag) begin
            lo_run <= 0;
            if (hi_run < QUAL_CYCLES) hi_run <= hi_run + 1;
        end else begin
            hi_run <= 0;
            if (lo_run < CLEAR_CYCLES) lo_run <= lo_run + 1;
        end
    end

    // R1
    trip_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tripped && oc_flag && hi_run + 1 >= QUAL_CYCLES) |=> tripped);

    // R1
    short_pulse_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tripped && !(oc_flag && hi_run + 1 >= QUAL_CYCLES)) |=> !tripped);

    // R2
    trip_forces_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tripped |-> (shutdown && fault_pull));

    // R3
    hold_while_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tripped && oc_flag) |=> tripped);

    // R4
    release_on_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tripped && !oc_flag && lo_run + 1 == CLEAR_CYCLES) |=> !tripped);

    // R5
    no_early_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tripped && !oc_flag && lo_run + 1 < CLEAR_CYCLES) |=> tripped);

    // R6
    uv_forces_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |-> (shutdown && fault_pull));

    // R7
    disable_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_enable |-> shutdown);

    // R9
    quiet_when_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_enable && !uv_flag && !tripped) |-> (!shutdown && !fault_pull));

endmodule

bind oc_protect_supervisor oc_protect_checker #(
    .QUAL_CYCLES  (QUAL_CYCLES),
    .CLEAR_CYCLES (CLEAR_CYCLES)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .oc_flag    (oc_flag),
    .uv_flag    (uv_flag),
    .drv_enable (drv_enable),
    .tripped    (tripped),
    .shutdown   (shutdown),
    .fault_pull (fault_pull)
);

// File: tb/oc_protect_supervisor_tb_top.sv
// Testbench: scoreboard bench for oc_protect_supervisor. The driver task sets
// inputs on the falling edge and queues the expected outputs. The monitor
// pops and compares a quarter period after the next rising edge.
module oc_protect_supervisor_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int QUAL  = 5;
    localparam int CLEAR = 20;
    localparam int WATCHDOG_CYCLES = 200000;

    typedef struct {
        logic  sd;
        logic  flt;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic oc_flag = 1'b0;
    logic uv_flag = 1'b0;
    logic drv_enable = 1'b0;
    logic shutdown;
    logic fault_pull;

    exp_t exp_q[$];
    int   checks   = 0;
    int   failures = 0;
    bit   done     = 1'b0;

    // Reference state derived from the requirements.
    int m_hi  = 0;
    int m_lo  = 0;
    bit m_lat = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oc_protect_supervisor #(
        .QUAL_CYCLES  (QUAL),
        .CLEAR_CYCLES (CLEAR)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .oc_flag    (oc_flag),
        .uv_flag    (uv_flag),
        .drv_enable (drv_enable),
        .shutdown   (shutdown),
        .fault_pull (fault_pull)
    );

    // Drive one cycle of inputs and queue the outputs expected after the next rising edge.
    task automatic step(input logic rst, input logic oc, input logic uv,
                        input logic en, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n      = rst;
        oc_flag    = oc;
        uv_flag    = uv;
        drv_enable = en;
        if (!rst) begin
            m_hi  = 0;
            m_lo  = 0;
            m_lat = 1'b0;
        end else begin
            if (oc) begin
                m_hi = m_hi + 1;
                m_lo = 0;
            end else begin
                m_hi = 0;
                m_lo = m_lo + 1;
            end
            if (!m_lat) begin
                if (oc && m_hi >= QUAL) m_lat = 1'b1;
            end else if (!oc && m_lo >= CLEAR) begin
                m_lat = 1'b0;
            end
        end
        e.sd  = m_lat | uv | ~en;
        e.flt = m_lat | uv;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic run(input int n, input logic rst, input logic oc,
                       input logic uv, input logic en, input string tag);
        for (int i = 0; i < n; i++) step(rst, oc, uv, en, tag);
    endtask

    // Monitor: compare each queued expectation away from the active edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (shutdown !== e.sd || fault_pull !== e.flt) begin
                    failures++;
                    $display("FAIL %s: shutdown=%b fault_pull=%b expected shutdown=%b fault_pull=%b at %0t",
                             e.tag, shutdown, fault_pull, e.sd, e.flt, $time);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        // R8: reset with trip high and enable low keeps latch clear
        run(3, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
        run(2, 1'b1, 1'b0, 1'b0, 1'b1, "R8");
        // R1: run of QUAL-1 high samples is ignored
        run(QUAL-1, 1'b1, 1'b1, 1'b0, 1'b1, "R1");
        run(3, 1'b1, 1'b0, 1'b0, 1'b1, "R1");
        // R1 R2: QUAL-th high sample latches the trip
        run(QUAL, 1'b1, 1'b1, 1'b0, 1'b1, "R2");
        // R3: long hold keeps it latched
        run(30, 1'b1, 1'b1, 1'b0, 1'b1, "R3");
        // R4: held for CLEAR-1 low samples, released on the CLEAR-th
        run(CLEAR-1, 1'b1, 1'b0, 1'b0, 1'b1, "R4");
        run(3, 1'b1, 1'b0, 1'b0, 1'b1, "R4");
        // R5: one-cycle glitch during blocking restarts the count
        run(QUAL, 1'b1, 1'b1, 1'b0, 1'b1, "R5");
        run(10, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
        run(1, 1'b1, 1'b1, 1'b0, 1'b1, "R5");
        run(CLEAR-1, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
        run(2, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
        // R5: qualified re-trip during blocking also restarts
        run(QUAL, 1'b1, 1'b1, 1'b0, 1'b1, "R5");
        run(8, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
        run(QUAL+2, 1'b1, 1'b1, 1'b0, 1'b1, "R5");
        run(CLEAR+2, 1'b1, 1'b0, 1'b0, 1'b1, "R5");
        // R6: undervoltage is transparent
        run(3, 1'b1, 1'b0, 1'b1, 1'b1, "R6");
        run(2, 1'b1, 1'b0, 1'b0, 1'b1, "R6");
        run(1, 1'b1, 1'b0, 1'b1, 1'b1, "R6");
        run(2, 1'b1, 1'b0, 1'b0, 1'b1, "R6");
        // R9: undervoltage ends while trip latched, fault stays
        run(QUAL, 1'b1, 1'b1, 1'b1, 1'b1, "R9");
        run(3, 1'b1, 1'b1, 1'b0, 1'b1, "R9");
        run(CLEAR+2, 1'b1, 1'b0, 1'b0, 1'b1, "R9");
        // R7: enable low forces shutdown only
        run(4, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
        run(2, 1'b1, 1'b0, 1'b0, 1'b1, "R7");
        // R8: reset in the middle of a latched trip clears it
        run(QUAL+1, 1'b1, 1'b1, 1'b0, 1'b1, "R8");
        run(1, 1'b0, 1'b0, 1'b0, 1'b1, "R8");
        run(3, 1'b1, 1'b0, 1'b0, 1'b1, "R8");

        repeat (3) @(posedge clk);
        #(CLK_PERIOD/2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule